// File: doc/BRIEF.md
# Page Write Buffer Engine

This block sits behind a two-wire serial slave and gathers the data bytes of one write transaction into a small buffer the size of one memory page. The slave front end loads the starting address with a strobe, then presents each received data byte with a valid strobe. The low address bits step through the page and wrap inside it, so extra bytes replace earlier ones at the same locations. When the transaction closes with STOP, the buffered bytes are written to the nonvolatile array in one operation. The write port carries a per-byte enable, so only the locations that received data change.

A transaction that is cut off by a repeated START, signalled on the abort input, discards whatever was buffered. After a commit the engine runs a timed programming window and raises a busy flag for its whole length. The slave uses that flag to refuse its address, which lets the bus master poll for the end of the write. All strobes are ignored while busy is high.

Top module: `pgwr_engine`

## Requirements
- R1: After reset, busy_o and mem_we_o are 0 and ptr_o is 0.
- R2: An accepted addr_load_i copies addr_i into ptr_o on the next cycle and discards any bytes buffered so far.
- R3: An accepted byte_vld_i stores byte_i at buffer slot ptr_o mod PAGE_BYTES. The low log2(PAGE_BYTES) bits of ptr_o then increment and wrap from PAGE_BYTES-1 to 0, and the upper bits do not change. For example, a start at 06h followed by 4 bytes uses 06h, 07h, 00h and 01h.
- R4: When more than PAGE_BYTES bytes arrive before STOP, each slot holds the last byte written to it, and only those final bytes are committed.
- R5: An accepted stop_i with at least one buffered byte raises mem_we_o for exactly the next cycle. mem_addr_o is then ptr_o with its low log2(PAGE_BYTES) bits cleared. Bit i of mem_be_o is 1 exactly when slot i was written, and byte lane i of mem_wdata_o (bits 8i+7..8i) holds that slot's data.
- R6: An accepted stop_i with no buffered byte causes no write and no busy period.
- R7: An accepted abort_i discards the buffered bytes and leaves ptr_o unchanged, so a later stop_i commits nothing.
- R8: After a commit, busy_o is 1 for exactly WR_CYCLES cycles, starting in the cycle where mem_we_o is 1.
- R9: While busy_o is 1, every input strobe is ignored: ptr_o does not change and no write follows.
- R10: After a commit, ptr_o holds the last written address plus one, wrapped within the page.
- R11: When strobes coincide, abort_i wins over stop_i, stop_i over addr_load_i, and addr_load_i over byte_vld_i. Only the winning strobe takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load_i | input | 1 | Load the starting address |
| addr_i | input | ADDR_W | Starting address |
| byte_vld_i | input | 1 | Data byte strobe |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Transaction ended with STOP |
| abort_i | input | 1 | Transaction cut off by a repeated START |
| busy_o | output | 1 | Programming window active |
| ptr_o | output | ADDR_W | Current address pointer |
| mem_we_o | output | 1 | Page write strobe, one cycle |
| mem_addr_o | output | ADDR_W | Page base address |
| mem_be_o | output | PAGE_BYTES | Per-byte enables |
| mem_wdata_o | output | PAGE_BYTES*DATA_W | Page data, slot i in lane i |

## Verification
The bench uses the default page of 8 bytes and an 8-bit address, so it reaches the wrap from slot 7 to slot 0 within a few bytes. WR_CYCLES is set to 5, which keeps the busy window short. Many commits then fit in one run, and strobes can land on the first cycle of busy, on its last cycle, and on the first idle cycle after it.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  // Base address of the page holding addr.
  function automatic int unsigned page_base(input int unsigned addr,
                                            input int unsigned page_bytes);
    return addr - (addr % page_bytes);
  endfunction

  // Next address with the in-page offset wrapping.
  function automatic int unsigned page_next(input int unsigned addr,
                                            input int unsigned page_bytes);
    return page_base(addr, page_bytes) + ((addr + 1) % page_bytes);
  endfunction

endpackage

// File: rtl/pgwr_ptr.sv
module pgwr_ptr #(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] ptr_o
);
  import pgwr_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_o <= '0;
    else if (load_i)
      ptr_o <= load_addr_i;
    else if (adv_i)
      ptr_o <= ADDR_W'(page_next(int'(ptr_o), PAGE_BYTES));
  end
endmodule

// File: rtl/pgwr_buffer.sv
module pgwr_buffer #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_i,
  input  logic [IDX_W-1:0]             idx_i,
  input  logic [DATA_W-1:0]            data_i,
  input  logic                         clr_i,
  output logic [PAGE_BYTES*DATA_W-1:0] data_o,
  output logic [PAGE_BYTES-1:0]        valid_o
);
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_i && (idx_i == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_o[g] <= 1'b0;
        data_o[g*DATA_W +: DATA_W] <= '0;
      end else begin
        if (clr_i)
          valid_o[g] <= 1'b0;
        else if (hit)
          valid_o[g] <= 1'b1;
        if (hit)
          data_o[g*DATA_W +: DATA_W] <= data_i;
      end
    end
  end

  // R7: discarding and storing never happen in the same cycle
  a_r7_clr_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_i && clr_i));
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int WR_CYCLES = 1000,
  localparam int CNT_W    = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (start_i)
      cnt <= CNT_W'(WR_CYCLES);
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);

  // R8: a new window never starts inside a running one
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o);
endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 1000,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int BUF_W     = PAGE_BYTES * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic              abort_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [PAGE_BYTES-1:0] mem_be_o,
  output logic [BUF_W-1:0]  mem_wdata_o
);
  import pgwr_pkg::*;

  // Named events, priority abort > stop > load > byte
  logic idle, ev_abort, ev_stop, ev_commit, ev_load, ev_byte, ev_clr;
  logic [BUF_W-1:0]      buf_data;
  logic [PAGE_BYTES-1:0] buf_valid;

  assign idle      = !busy_o;
  assign ev_abort  = idle && abort_i;
  assign ev_stop   = idle && !abort_i && stop_i;
  assign ev_commit = ev_stop && (buf_valid != '0);
  assign ev_load   = idle && !abort_i && !stop_i && addr_load_i;
  assign ev_byte   = idle && !abort_i && !stop_i && !addr_load_i && byte_vld_i;
  assign ev_clr    = ev_abort || ev_stop || ev_load;

  pgwr_ptr #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ptr (
    .clk, .rst_n,
    .load_i(ev_load), .load_addr_i(addr_i), .adv_i(ev_byte), .ptr_o(ptr_o)
  );

  pgwr_buffer #(.DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk, .rst_n,
    .wr_i(ev_byte), .idx_i(ptr_o[IDX_W-1:0]), .data_i(byte_i),
    .clr_i(ev_clr), .data_o(buf_data), .valid_o(buf_valid)
  );

  pgwr_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk, .rst_n, .start_i(ev_commit), .busy_o(busy_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_be_o    <= '0;
      mem_wdata_o <= '0;
    end else begin
      mem_we_o <= ev_commit;
      if (ev_commit) begin
        mem_addr_o  <= ADDR_W'(page_base(int'(ptr_o), PAGE_BYTES));
        mem_be_o    <= buf_valid;
        mem_wdata_o <= buf_data;
      end
    end
  end

  // R5: write strobe lasts one cycle and always enables some byte
  a_r5_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o);
  a_r5_be_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_be_o != '0));
  // R8: busy window opens together with the write
  a_r8_rise_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> mem_we_o);
  a_r8_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);
  // R9: pointer frozen while busy
  a_r9_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(ptr_o));
  // R3: byte stepping stays within the page
  a_r3_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte |=> ((ptr_o >> IDX_W) == ($past(ptr_o) >> IDX_W)));
endmodule

// File: tb/pgwr_engine_bench.sv
module pgwr_engine_bench;
  localparam int WRC = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_load_i = 0, byte_vld_i = 0, stop_i = 0, abort_i = 0;
  logic [7:0] addr_i = 0, byte_i = 0;
  logic busy_o, mem_we_o;
  logic [7:0] ptr_o, mem_addr_o, mem_be_o;
  logic [63:0] mem_wdata_o;

  always #4 clk = ~clk;

  pgwr_engine #(.ADDR_W(8), .DATA_W(8), .PAGE_BYTES(8), .WR_CYCLES(WRC)) u_pgwr_engine (
    .clk, .rst_n, .addr_load_i, .addr_i, .byte_vld_i, .byte_i, .stop_i, .abort_i,
    .busy_o, .ptr_o, .mem_we_o, .mem_addr_o, .mem_be_o, .mem_wdata_o
  );

  int total = 0, bad = 0;
  bit done = 0;
  string tag = "R1";

  // Behavioural reference
  int  m_ptr = 0, m_cnt = 0, m_addr = 0;
  bit  m_val[8];
  int  m_dat[8];
  bit  m_we = 0;
  bit  m_be[8];
  int  m_wd[8];

  task automatic chk(string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(bit ld, int a, bit bv, int d, bit st, bit ab);
    bit any = 0;
    m_we = 0;
    if (m_cnt > 0) begin
      m_cnt--;
    end else if (ab) begin
      foreach (m_val[i]) m_val[i] = 0;
    end else if (st) begin
      foreach (m_val[i]) any |= m_val[i];
      if (any) begin
        m_we = 1; m_cnt = WRC; m_addr = (m_ptr / 8) * 8;
        foreach (m_val[i]) begin m_be[i] = m_val[i]; m_wd[i] = m_dat[i]; end
      end
      foreach (m_val[i]) m_val[i] = 0;
    end else if (ld) begin
      m_ptr = a;
      foreach (m_val[i]) m_val[i] = 0;
    end else if (bv) begin
      m_dat[m_ptr % 8] = d; m_val[m_ptr % 8] = 1;
      m_ptr = (m_ptr / 8) * 8 + (m_ptr + 1) % 8;
    end
  endtask

  task automatic compare();
    chk("busy", busy_o, m_cnt > 0);
    chk("we", mem_we_o, m_we);
    chk("ptr", ptr_o, m_ptr);
    if (m_we && mem_we_o) begin
      chk("addr", mem_addr_o, m_addr);
      for (int i = 0; i < 8; i++) begin
        chk("be", mem_be_o[i], m_be[i]);
        if (m_be[i]) chk("data", mem_wdata_o[i*8 +: 8], m_wd[i]);
      end
    end
  endtask

  task automatic step(bit ld, int a, bit bv, int d, bit st, bit ab);
    addr_load_i = ld; addr_i = 8'(a); byte_vld_i = bv; byte_i = 8'(d);
    stop_i = st; abort_i = ab;
    @(posedge clk);
    model(ld, a, bv, d, st, ab);
    @(negedge clk);
    compare();
    addr_load_i = 0; byte_vld_i = 0; stop_i = 0; abort_i = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic drain();
    while (m_cnt > 0) step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    foreach (m_val[i]) begin m_val[i] = 0; m_dat[i] = 0; m_be[i] = 0; m_wd[i] = 0; end
    repeat (3) @(negedge clk);
    tag = "R1"; compare();
    rst_n = 1;
    idle(2);

    // Wrapping page write then busy window
    tag = "R3"; step(1, 'h06, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 'hA0 + i, 0, 0);
    tag = "R5"; step(0, 0, 0, 0, 1, 0);
    tag = "R8"; drain();
    tag = "R10"; chk("ptr after commit", ptr_o, 'h02);

    // Overrun of the page
    tag = "R4"; step(1, 'h13, 0, 0, 0, 0);
    for (int i = 0; i < 11; i++) step(0, 0, 1, 'h30 + i, 0, 0);
    step(0, 0, 0, 0, 1, 0);
    chk("lane0 newest", mem_wdata_o[7:0], 'h35);
    drain();

    // Empty stop
    tag = "R6"; step(1, 'h20, 0, 0, 0, 0); step(0, 0, 0, 0, 1, 0);
    chk("no busy", busy_o, 0); idle(2);

    // Abort, then stop commits nothing
    tag = "R7"; step(1, 'h30, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 'h55, 0, 0);
    step(0, 0, 0, 0, 0, 1); chk("ptr kept", ptr_o, 'h33);
    step(0, 0, 0, 0, 1, 0); idle(2);

    // Strobes during busy
    tag = "R2"; step(1, 'h41, 0, 0, 0, 0); step(0, 0, 1, 'h11, 0, 0);
    step(1, 'h48, 0, 0, 0, 0); step(0, 0, 1, 'h22, 0, 0);
    tag = "R9"; step(0, 0, 0, 0, 1, 0);
    step(1, 'h77, 0, 0, 0, 0); step(0, 0, 1, 'h99, 0, 0); step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1); drain(); chk("ptr frozen", ptr_o, 'h49);

    // Coinciding strobes
    tag = "R11"; step(1, 'h50, 0, 0, 0, 0); step(0, 0, 1, 'h01, 0, 0);
    step(0, 0, 1, 'h02, 1, 1);
    step(0, 0, 1, 'h03, 0, 0); step(1, 'h58, 1, 'h04, 0, 0);
    step(0, 0, 1, 'h05, 1, 0); drain();
    step(1, 'h60, 1, 'h06, 0, 0); step(0, 0, 1, 'h07, 0, 0); step(1, 'h00, 1, 'h08, 1, 0);
    drain();

    // Mixed traffic
    tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 100);
      step(r < 5, int'($urandom % 256), r >= 5 && r < 75, int'($urandom % 256),
           r >= 75 && r < 85 || r == 99, r >= 85 && r < 88);
    end
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule